// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing half of a serial port. A processor reaches it through a simple register bus with separate read and write strobes, an address inside a 1 KiB window and 32-bit data. On the line side it trades whole characters with a framing engine that lives elsewhere. It hands out one transmit byte with a single-cycle valid strobe, and it takes in one receive byte under a valid/ready handshake.

Inside are seven registers: a status word, a data register, a baud divisor, three control words and a guard-time word. The divisor, the second and third control words and the guard-time word are plain storage that other logic may read. The block keeps three status flags up to date: receive-ready, transmit-complete and transmit-empty. It only stores a received character when the first control word enables both the peripheral and the receiver. Its single level interrupt follows the flags that the first control word masks in.

Top module: `usart_front`

## Requirements
- R1: `irq` is a register. In the cycle after any change to its inputs it equals the OR over bits 5, 6 and 7 of (status AND control-1). It is low out of reset.
- R2: A character offered on `rx_data` while control-1 bit 13 (peripheral enable) or bit 2 (receiver enable) is clear is consumed and discarded. The data register and receive-ready are left as they were.
- R3: `rx_ready` is high exactly while status bit 5 (receive-ready) is clear. An accepted, enabled character is loaded into the data register and sets bit 5 on the next cycle.
- R4: Read data of the data register (offset 0x04) is its low 10 bits. A read strobe there clears status bit 5.
- R5: A status write (offset 0x00) of a value up to 0x3FF replaces the status word with that value, with bit 7 (transmit-empty) forced to 1. A larger value is ANDed into the current status word.
- R6: A data-register write below 0xF000 makes `tx_valid` high for one cycle on the next cycle, with `tx_data` equal to the written low byte, and it sets status bit 6 (transmit-complete). Writes of 0xF000 or more change nothing.
- R7: After reset, status reads 0x000000C0 and every other register reads zero.
- R8: Baud (0x08), control-1 (0x0C), control-2 (0x10), control-3 (0x14) and guard (0x18) read back the last value written. Any other offset reads zero, and writes to it have no effect.
- R9: If a status write or a data-register read coincides with an accepted, enabled character, the character's effect wins: bit 5 ends set and the data register holds the new character. Receive gating uses control-1 as it was before a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 10 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_data | output | 8 | Transmit character |
| tx_valid | output | 1 | One-cycle strobe marking `tx_data` |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Received character offered |
| rx_ready | output | 1 | Block can take a character |
| irq | output | 1 | Level interrupt |

## Verification
The embedded assertions check every cycle that the interrupt matches the masked flags and that a transmit strobe carries the written byte and raises transmit-complete. They also check that an overwrite-mode status write leaves transmit-empty set, that an AND-clear never sets a bit, and that a data-register read drops receive-ready. For receive, they check that an accepted character lands in the data register and that a gated-off one leaves it alone. Only the bench scenarios show the reset image, the read-back of the storage-only registers, the silence of unmapped offsets, the exact 0xF000 boundary, and the same-cycle ordering between a status write and an arriving character. A random phase mixes all of these cases against a behavioural model.

// File: rtl/usart_front_pkg.sv
// Package: register offsets, flag positions and constants shared by the
// serial port register front end. Assumes a byte-addressed window of 1 KiB.
package usart_front_pkg;

    localparam int unsigned OFS_STAT  = 'h000;
    localparam int unsigned OFS_DATA  = 'h004;
    localparam int unsigned OFS_BAUD  = 'h008;
    localparam int unsigned OFS_CTL1  = 'h00C;
    localparam int unsigned OFS_CTL2  = 'h010;
    localparam int unsigned OFS_CTL3  = 'h014;
    localparam int unsigned OFS_GUARD = 'h018;

    localparam int unsigned BIT_RXRDY  = 5;
    localparam int unsigned BIT_TXDONE = 6;
    localparam int unsigned BIT_TXEMPT = 7;
    localparam int unsigned BIT_RXEN   = 2;
    localparam int unsigned BIT_PEN    = 13;

    localparam logic [31:0] STAT_RESET    = 32'h0000_00C0;
    localparam logic [31:0] OVERWRITE_MAX = 32'h0000_03FF;
    localparam logic [31:0] TX_LIMIT      = 32'h0000_F000;
    localparam int unsigned RD_KEEP_W     = 10;

    // storage-only bank slots, in address order
    localparam int unsigned NUM_CFG  = 5;
    localparam int unsigned SLOT_BAUD  = 0;
    localparam int unsigned SLOT_CTL1  = 1;
    localparam int unsigned SLOT_CTL2  = 2;
    localparam int unsigned SLOT_CTL3  = 3;
    localparam int unsigned SLOT_GUARD = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_DATA,
        SEL_BAUD,
        SEL_CTL1,
        SEL_CTL2,
        SEL_CTL3,
        SEL_GUARD
    } reg_sel_e;

endpackage

// File: rtl/usart_addr_dec.sv
// Address decoder: maps a byte offset onto a register select.
// Assumes exact-offset matching; anything else, including unaligned offsets,
// selects nothing.
module usart_addr_dec
    import usart_front_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // decode one offset to one register
    always_comb begin
        unique case (addr)
            ADDR_W'(OFS_STAT):  sel = SEL_STAT;
            ADDR_W'(OFS_DATA):  sel = SEL_DATA;
            ADDR_W'(OFS_BAUD):  sel = SEL_BAUD;
            ADDR_W'(OFS_CTL1):  sel = SEL_CTL1;
            ADDR_W'(OFS_CTL2):  sel = SEL_CTL2;
            ADDR_W'(OFS_CTL3):  sel = SEL_CTL3;
            ADDR_W'(OFS_GUARD): sel = SEL_GUARD;
            default:            sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/usart_cfg_bank.sv
// Storage bank: a row of plain write/read-back words (baud, control words,
// guard time). Assumes at most one write enable is active per cycle.
module usart_cfg_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM-1:0]             wr_en,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM-1:0][DATA_W-1:0] regs
);

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        // hold one word, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n)        regs[g] <= '0;
            else if (wr_en[g]) regs[g] <= wdata;
        end
    end

endmodule

// File: rtl/usart_rx_path.sv
// Receive path: handshakes a character in, drops it when gated off, and
// keeps it in the data register. Assumes rx_full mirrors receive-ready.
module usart_rx_path #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_full,
    input  logic              en_periph,
    input  logic              en_rx,
    output logic              rx_ready,
    output logic              rx_store,
    output logic [CHAR_W-1:0] data_q
);

    logic gate_open;

    // handshake and gating decision
    always_comb begin
        rx_ready  = !rx_full;
        gate_open = en_periph && en_rx;
        rx_store  = rx_valid && rx_ready && gate_open;
    end

    // data register load
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (rx_store) data_q <= rx_data;
    end

    AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store |=> (data_q == $past(rx_data))); // R3

    AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !gate_open) |=> $stable(data_q)); // R2

endmodule

// File: rtl/usart_status_ctl.sv
// Status and event logic: next-state of the flag word, the transmit strobe
// and the registered interrupt. Assumes the caller passes control-1 both as
// stored now and as it will be after this cycle's write.
module usart_status_ctl
    import usart_front_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_fire,
    input  logic              rd_clear,
    input  logic              rx_store,
    input  logic [DATA_W-1:0] ctl1_q,
    input  logic [DATA_W-1:0] ctl1_nxt,
    output logic [DATA_W-1:0] stat_q,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output logic              irq
);

    localparam logic [DATA_W-1:0] IRQ_MASK = (DATA_W'(1) << BIT_RXRDY)
                                           | (DATA_W'(1) << BIT_TXDONE)
                                           | (DATA_W'(1) << BIT_TXEMPT);
    localparam logic [DATA_W-1:0] OVR_MAX  = DATA_W'(OVERWRITE_MAX);

    logic [DATA_W-1:0] stat_nxt;
    logic              irq_nxt;

    // apply bus write, then transmit, read clear, and receive last
    always_comb begin
        stat_nxt = stat_q;
        if (stat_wr) begin
            if (wdata <= OVR_MAX) stat_nxt = wdata | (DATA_W'(1) << BIT_TXEMPT);
            else                  stat_nxt = stat_q & wdata;
        end
        if (tx_fire)  stat_nxt[BIT_TXDONE] = 1'b1;
        if (rd_clear) stat_nxt[BIT_RXRDY]  = 1'b0;
        if (rx_store) stat_nxt[BIT_RXRDY]  = 1'b1;
        irq_nxt = |(stat_nxt & ctl1_nxt & IRQ_MASK);
    end

    // register status, interrupt and transmit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q   <= DATA_W'(STAT_RESET);
            irq      <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            stat_q   <= stat_nxt;
            irq      <= irq_nxt;
            tx_valid <= tx_fire;
            if (tx_fire) tx_data <= wdata[CHAR_W-1:0];
        end
    end

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(stat_q & ctl1_q & IRQ_MASK)); // R1

    AST_TXEMPTY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata <= OVR_MAX) |=> stat_q[BIT_TXEMPT]); // R5

    AST_AND_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata > OVR_MAX && !rx_store)
        |=> ((stat_q & ~$past(stat_q)) == '0)); // R5

    AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |=> (tx_valid && tx_data == $past(wdata[CHAR_W-1:0])
                     && stat_q[BIT_TXDONE])); // R6

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !rx_store) |=> !stat_q[BIT_RXRDY]); // R4

endmodule

// File: rtl/usart_front.sv
// Top: register bus front end of a serial port. Decodes the bus, routes
// writes and read side effects, muxes read data combinationally.
// Assumes read and write strobes are single-cycle and one register at a time.
module usart_front
    import usart_front_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              irq
);

    localparam logic [DATA_W-1:0] RD_MASK  = DATA_W'((64'd1 << RD_KEEP_W) - 1);
    localparam logic [DATA_W-1:0] TX_LIM_W = DATA_W'(TX_LIMIT);

    reg_sel_e                       sel;
    logic [NUM_CFG-1:0]             cfg_wr;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0]              stat_q;
    logic [DATA_W-1:0]              ctl1_nxt;
    logic [CHAR_W-1:0]              data_q;
    logic                           stat_wr, tx_fire, rd_clear, rx_store;

    usart_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    // route strobes to the register that owns the offset
    always_comb begin
        stat_wr  = bus_wr && (sel == SEL_STAT);
        tx_fire  = bus_wr && (sel == SEL_DATA) && (bus_wdata < TX_LIM_W);
        rd_clear = bus_rd && (sel == SEL_DATA);
        cfg_wr   = '0;
        cfg_wr[SLOT_BAUD]  = bus_wr && (sel == SEL_BAUD);
        cfg_wr[SLOT_CTL1]  = bus_wr && (sel == SEL_CTL1);
        cfg_wr[SLOT_CTL2]  = bus_wr && (sel == SEL_CTL2);
        cfg_wr[SLOT_CTL3]  = bus_wr && (sel == SEL_CTL3);
        cfg_wr[SLOT_GUARD] = bus_wr && (sel == SEL_GUARD);
        ctl1_nxt = cfg_wr[SLOT_CTL1] ? bus_wdata : cfg_q[SLOT_CTL1];
    end

    usart_cfg_bank #(.DATA_W(DATA_W), .NUM(NUM_CFG)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (bus_wdata),
        .regs  (cfg_q)
    );

    usart_rx_path #(.CHAR_W(CHAR_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_full   (stat_q[BIT_RXRDY]),
        .en_periph (cfg_q[SLOT_CTL1][BIT_PEN]),
        .en_rx     (cfg_q[SLOT_CTL1][BIT_RXEN]),
        .rx_ready  (rx_ready),
        .rx_store  (rx_store),
        .data_q    (data_q)
    );

    usart_status_ctl #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) st_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_wr  (stat_wr),
        .wdata    (bus_wdata),
        .tx_fire  (tx_fire),
        .rd_clear (rd_clear),
        .rx_store (rx_store),
        .ctl1_q   (cfg_q[SLOT_CTL1]),
        .ctl1_nxt (ctl1_nxt),
        .stat_q   (stat_q),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .irq      (irq)
    );

    // read data multiplexer
    always_comb begin
        unique case (sel)
            SEL_STAT:  bus_rdata = stat_q;
            SEL_DATA:  bus_rdata = DATA_W'(data_q) & RD_MASK;
            SEL_BAUD:  bus_rdata = cfg_q[SLOT_BAUD];
            SEL_CTL1:  bus_rdata = cfg_q[SLOT_CTL1];
            SEL_CTL2:  bus_rdata = cfg_q[SLOT_CTL2];
            SEL_CTL3:  bus_rdata = cfg_q[SLOT_CTL3];
            SEL_GUARD: bus_rdata = cfg_q[SLOT_GUARD];
            default:   bus_rdata = '0;
        endcase
    end

    AST_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_DATA && bus_wdata >= TX_LIM_W) |=> !tx_valid); // R6

    AST_RX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store && (stat_wr || rd_clear)) |=> !rx_ready); // R9

endmodule

// File: tb/usart_front_tb_top.sv
// Bench: behavioural reference model updated on every rising edge and
// compared against the design on every falling edge, plus directed scenarios.
module usart_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit started = 0;

    always #4 clk = ~clk; // 125 MHz

    usart_front dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
    );

    // reference state
    logic [31:0] m_sr, m_dr;
    logic [31:0] m_cfg [5];
    logic        m_irq, m_txv;
    logic [7:0]  m_txd;

    function automatic int cfg_slot(input logic [9:0] a);
        case (a)
            10'h008: return 0;
            10'h00C: return 1;
            10'h010: return 2;
            10'h014: return 3;
            10'h018: return 4;
            default: return -1;
        endcase
    endfunction

    // model: one behavioural step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sr = 32'hC0; m_dr = 0; m_irq = 0; m_txv = 0; m_txd = 0;
            foreach (m_cfg[i]) m_cfg[i] = 0;
        end else begin
            logic [31:0] n_sr, n_ctl;
            bit take;
            int s;
            n_sr = m_sr;
            take = rx_valid && !m_sr[5] && m_cfg[1][13] && m_cfg[1][2];
            m_txv = 0;
            if (bus_wr) begin
                s = cfg_slot(bus_addr);
                if (bus_addr == 10'h000)
                    n_sr = (bus_wdata <= 32'h3FF) ? (bus_wdata | 32'h80) : (m_sr & bus_wdata);
                else if (bus_addr == 10'h004 && bus_wdata < 32'hF000) begin
                    n_sr[6] = 1; m_txv = 1; m_txd = bus_wdata[7:0];
                end else if (s >= 0) m_cfg[s] = bus_wdata;
            end
            if (bus_rd && bus_addr == 10'h004) n_sr[5] = 0;
            if (take) begin n_sr[5] = 1; m_dr = {24'd0, rx_data}; end
            m_sr = n_sr;
            n_ctl = m_cfg[1];
            m_irq = |(m_sr & n_ctl & 32'hE0);
        end
    end

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [9:0] a);
        int s;
        s = cfg_slot(a);
        if (a == 10'h000) return m_sr;
        if (a == 10'h004) return m_dr & 32'h3FF;
        if (s >= 0) return m_cfg[s];
        return 0;
    endfunction

    function automatic string rd_tag(input logic [9:0] a);
        if (a == 10'h000) return "R5 status";
        if (a == 10'h004) return "R4 data";
        return "R8 map";
    endfunction

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && rst_n) begin
            cmp({31'd0, irq}, {31'd0, m_irq}, "R1 irq");
            cmp({31'd0, rx_ready}, {31'd0, !m_sr[5]}, "R3 rx_ready");
            cmp({31'd0, tx_valid}, {31'd0, m_txv}, "R6 tx_valid");
            if (m_txv) cmp({24'd0, tx_data}, {24'd0, m_txd}, "R6 tx_data");
            cmp(bus_rdata, m_read(bus_addr), rd_tag(bus_addr));
        end
    end

    // one bus/line cycle, then back to idle
    task automatic cyc(input bit wr, input bit rd, input logic [9:0] a,
                       input logic [31:0] d, input bit rv, input logic [7:0] rd_ch);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_data = rd_ch;
        @(posedge clk); #1;
        bus_wr = 0; bus_rd = 0; rx_valid = 0;
    endtask

    // directed read-back check at an explicit value, without side effects
    task automatic chk(input logic [9:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        cmp(bus_rdata, exp, tag);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion (R1..all)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1; started = 1;
        // R7 reset image
        chk(10'h000, 32'hC0, "R7 status reset");
        chk(10'h004, 0, "R7 data reset");
        for (int i = 0; i < 5; i++) chk(10'h008 + 10'(4*i), 0, "R7 cfg reset");
        cmp({31'd0, irq}, 0, "R7 irq reset");
        // R8 storage and unmapped offsets
        wr(10'h008, 32'h1234_5678); wr(10'h010, 32'hA5A5_0001);
        wr(10'h014, 32'hFFFF_FFFF); wr(10'h018, 32'h0000_00FF);
        wr(10'h01C, 32'hDEAD_BEEF); wr(10'h3FC, 32'h1111_1111); wr(10'h002, 32'h2);
        chk(10'h008, 32'h1234_5678, "R8 baud");
        chk(10'h010, 32'hA5A5_0001, "R8 ctl2");
        chk(10'h01C, 0, "R8 unmapped");
        chk(10'h3FC, 0, "R8 unmapped top");
        chk(10'h002, 0, "R8 unaligned");
        // R1 interrupt from transmit-empty when enabled
        wr(10'h00C, 32'h0000_0080);
        cmp({31'd0, irq}, 1, "R1 irq txempty");
        // R2 receive discarded while gated off
        cyc(0, 0, 10'h000, 0, 1, 8'h3C);
        chk(10'h004, 0, "R2 dropped char");
        wr(10'h00C, 32'h0000_2000);
        cyc(0, 0, 10'h000, 0, 1, 8'h3D);
        chk(10'h004, 0, "R2 rx disabled");
        // R3 enabled receive, back-pressure
        wr(10'h00C, 32'h0000_2024);
        cyc(0, 0, 10'h000, 0, 1, 8'h9E);
        chk(10'h004, 32'h9E, "R3 stored char");
        cmp({31'd0, rx_ready}, 0, "R3 back-pressure");
        cyc(0, 0, 10'h000, 0, 1, 8'h55);
        chk(10'h004, 32'h9E, "R3 held while full");
        // R4 read clears
        cyc(0, 1, 10'h004, 0, 0, 0);
        chk(10'h000, 32'hC0, "R4 rxrdy cleared");
        // R5 both write modes
        wr(10'h000, 32'h0000_0000);
        chk(10'h000, 32'h80, "R5 overwrite forces txempty");
        wr(10'h000, 32'h0000_03FF);
        chk(10'h000, 32'h3FF, "R5 overwrite max");
        wr(10'h000, 32'hFFFF_FF7F);
        chk(10'h000, 32'h37F, "R5 and-clear");
        // R6 transmit boundary
        wr(10'h000, 32'h0);
        cyc(1, 0, 10'h004, 32'h0000_EFFF, 0, 0);
        cmp({31'd0, tx_valid}, 1, "R6 strobe");
        cmp({24'd0, tx_data}, 32'hFF, "R6 byte");
        chk(10'h000, 32'hC0, "R6 txdone set");
        wr(10'h000, 32'h0);
        cyc(1, 0, 10'h004, 32'h0000_F000, 0, 0);
        cmp({31'd0, tx_valid}, 0, "R6 ignored");
        chk(10'h000, 32'h80, "R6 ignored status");
        // R9 same-cycle priority
        cyc(1, 0, 10'h000, 32'h0, 1, 8'h42);
        chk(10'h000, 32'hA0, "R9 rx after status write");
        cyc(0, 1, 10'h004, 0, 0, 0);
        cyc(0, 1, 10'h004, 0, 1, 8'h43);
        chk(10'h004, 32'h43, "R9 rx after data read");
        cyc(1, 0, 10'h00C, 32'h0, 0, 0);
        cyc(0, 1, 10'h004, 0, 0, 0);
        cyc(1, 0, 10'h00C, 32'h2004, 1, 8'h44);
        chk(10'h004, 32'h43, "R9 gating uses old ctl1");
        // random mix against the model
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [9:0] a;
            logic [31:0] d;
            op = int'($urandom % 6);
            case ($urandom % 9)
                0: a = 10'h000; 1: a = 10'h004; 2: a = 10'h008; 3: a = 10'h00C;
                4: a = 10'h010; 5: a = 10'h014; 6: a = 10'h018; 7: a = 10'h01C;
                default: a = 10'h3FC;
            endcase
            case ($urandom % 4)
                0: d = $urandom & 32'h3FF;
                1: d = $urandom | 32'hFFFF_FC00;
                2: d = 32'hEFF0 + ($urandom % 32);
                default: d = (a == 10'h00C) ? ($urandom & 32'h20E4) : $urandom;
            endcase
            case (op)
                0, 1: cyc(1, 0, a, d, $urandom % 2, 8'($urandom));
                2:    cyc(0, 1, 10'h004, 0, $urandom % 2, 8'($urandom));
                3:    cyc(0, 0, a, 0, 1, 8'($urandom));
                default: cyc(0, 0, a, 0, 0, 0);
            endcase
        end
        repeat (2) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule